// File: doc/BRIEF.md
# Quarter-Wave Phase-Modulated Sine Synthesizer

This block is a numerically controlled oscillator that produces a sampled sine wave for a 10-bit current-steering converter. A phase register grows by a programmable step every clock. A two-bit phase-shift-keying code adds a whole number of quarter turns to that phase before it is turned into an amplitude. This gives the four phase states of a simple PSK modulator, and the accumulator itself is never touched.

Only one quarter of a sine period is stored. The other three quarters come from reading the quarter table backwards and from a separate sign. Each sample is held internally as a sign bit and an 11-bit magnitude. The output word keeps the sign as its top bit and the upper nine magnitude bits below it. The sign is also driven on a dedicated invert line, which a converter with a lower-bits complement input can use. Software loads the step word through a single write strobe before it starts the carrier.

Top module: `qw_nco`

## Requirements
- R1: While reset is high on a clock edge, the phase register and the step word are cleared. After reset falls, `dac` and `inv` read zero for one more cycle. The next sample then belongs to phase zero.
- R2: When `fw_wr` is high on a clock edge, `fw_data` becomes the step word at that edge. The phase register adds the new step from the following edge on, every clock, modulo 2^32.
- R3: The phase used for a sample is the index i = phase[31:22] plus a quarter-turn offset taken from `pm`: 00 adds 0, 01 adds 256, 11 adds 512 and 10 adds 768, all modulo 1024.
- R4: `dac[8:0]` lies within 2 counts of 2047·|sin θ|/4, where θ = 2π(i+0.5)/1024.
- R5: `dac[9]` is 1 exactly when θ lies in the negative half-cycle (i ≥ 512). `inv` always equals `dac[9]`.
- R6: The magnitude field is the same for index i, for its mirror 511−i, and for i+512, for every i from 0 to 255. The sign is 0 for the first of these and 1 for the last.
- R7: A change of `pm` moves only the sample's phase. The phase register keeps advancing by the step word exactly as before.
- R8: A value of the phase register and of `pm` that is present at a clock edge appears on `dac` and `inv` after the next clock edge. That is a fixed two-edge latency.
- R9: While `fw_wr` is low, changes on `fw_data` have no effect on the step word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fw_wr | input | 1 | Write strobe for the step word |
| fw_data | input | 32 | Step word written when the strobe is high |
| pm | input | 2 | Phase-shift code, quarter-turn offset |
| dac | output | 10 | Converter word: sign in bit 9, magnitude in bits 8:0 |
| inv | output | 1 | Invert control, high during the negative half-cycle |

## Verification
The synthesizer is driven with coarse step words at each of the four shift codes. Any error in the code-to-offset mapping then shows up as a sign or magnitude error at a known phase. A unit step is also used so that every one of the 1024 phase indices appears; this exposes a wrong table entry or a mirroring fault, and the recorded samples are then compared for exact quarter-wave symmetry. A step that is negative as an unsigned wrap, and an arbitrary large step, test the modulo arithmetic of the accumulator. With the step frozen at zero, the shift code is switched to measure the two-cycle latency, and the data bus is toggled without a strobe to show that the step word holds.

// File: rtl/qw_nco_pkg.sv
`timescale 1ns/100ps
package qw_nco_pkg;

   // Quarter-turn offset added to the phase for each shift code
   function automatic logic [1:0] pm_quarters(input logic [1:0] code);
      logic [1:0] q;
      case (code)
         2'b00:   q = 2'd0;
         2'b01:   q = 2'd1;
         2'b10:   q = 2'd3;
         default: q = 2'd2;
      endcase
      return q;
   endfunction

   // Integer rational sine approximation, sampled at half-step centres
   // over one quarter turn; used only to build the table at elaboration.
   function automatic longint quarter_amp(input int idx, input int addr_w,
                                          input longint mag_max);
      longint n, h, p, q, num, den;
      n   = longint'(1) << addr_w;
      h   = 4 * n;
      p   = 2 * longint'(idx) + 1;
      q   = p * (h - p);
      num = 16 * q;
      den = 5 * h * h - 4 * q;
      return (mag_max * num + den / 2) / den;
   endfunction

endpackage

// File: rtl/qw_phase_acc.sv
`timescale 1ns/100ps
module qw_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fw_wr,
   input  logic [ACC_W-1:0] fw_data,
   output logic [ACC_W-1:0] fw_q,
   output logic [ACC_W-1:0] acc_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         fw_q  <= '0;
         acc_q <= '0;
      end else begin
         if (fw_wr) begin
            fw_q <= fw_data;
         end
         acc_q <= acc_q + fw_q;
      end
   end

endmodule

// File: rtl/qw_quadrant_map.sv
`timescale 1ns/100ps
module qw_quadrant_map
   import qw_nco_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ACC_W-1:0]  acc_q,
   input  logic [1:0]        pm,
   output logic [ADDR_W-1:0] addr_q,
   output logic              neg_q,
   output logic              vld_q
);

   localparam int QTOP = ACC_W - 1;
   localparam int ATOP = ACC_W - 3;

   logic [1:0]        quad;
   logic [ADDR_W-1:0] raw_addr;
   logic [ADDR_W-1:0] map_addr;

   always_comb begin
      quad     = acc_q[QTOP -: 2] + pm_quarters(pm);
      raw_addr = acc_q[ATOP -: ADDR_W];
      // odd quarters run the table backwards
      map_addr = quad[0] ? ~raw_addr : raw_addr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         neg_q  <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         addr_q <= map_addr;
         neg_q  <= quad[1];
         vld_q  <= 1'b1;
      end
   end

endmodule

// File: rtl/qw_quarter_rom.sv
`timescale 1ns/100ps
module qw_quarter_rom
   import qw_nco_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int SAMPLE_W = 12,
   parameter int DAC_W    = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              neg_q,
   input  logic              vld_q,
   output logic [DAC_W-1:0]  dac,
   output logic              inv
);

   localparam int     DEPTH   = 1 << ADDR_W;
   localparam int     MAG_W   = SAMPLE_W - 1;
   localparam int     OMAG_W  = DAC_W - 1;
   localparam longint MAG_MAX = (longint'(1) << MAG_W) - 1;

   logic [MAG_W-1:0]  tbl [DEPTH];
   logic [MAG_W-1:0]  mag;
   logic [OMAG_W-1:0] omag;

   for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
      localparam longint AMP = quarter_amp(g, ADDR_W, MAG_MAX);
      assign tbl[g] = AMP[MAG_W-1:0];
   end

   assign mag = tbl[addr_q];

   if (OMAG_W == MAG_W) begin : g_full
      assign omag = mag;
   end else begin : g_trunc
      assign omag = mag[MAG_W-1 -: OMAG_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dac <= '0;
         inv <= 1'b0;
      end else if (vld_q) begin
         dac <= {neg_q, omag};
         inv <= neg_q;
      end else begin
         dac <= '0;
         inv <= 1'b0;
      end
   end

endmodule

// File: rtl/qw_nco.sv
`timescale 1ns/100ps
module qw_nco #(
   parameter int ACC_W    = 32,
   parameter int ADDR_W   = 8,
   parameter int SAMPLE_W = 12,
   parameter int DAC_W    = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fw_wr,
   input  logic [ACC_W-1:0] fw_data,
   input  logic [1:0]       pm,
   output logic [DAC_W-1:0] dac,
   output logic             inv
);

   if (ACC_W < ADDR_W + 2) begin : g_bad_acc
      $error("qw_nco: ACC_W too small for quadrant and table address");
   end
   if (DAC_W > SAMPLE_W || DAC_W < 2) begin : g_bad_dac
      $error("qw_nco: DAC_W must lie between 2 and SAMPLE_W");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("qw_nco: ADDR_W out of range");
   end

   logic [ACC_W-1:0]  fw_q;
   logic [ACC_W-1:0]  acc_q;
   logic [ADDR_W-1:0] addr_q;
   logic              neg_q;
   logic              vld_q;

   qw_phase_acc #(.ACC_W(ACC_W)) i_acc (
      .clk     (clk),
      .rst     (rst),
      .fw_wr   (fw_wr),
      .fw_data (fw_data),
      .fw_q    (fw_q),
      .acc_q   (acc_q)
   );

   qw_quadrant_map #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) i_map (
      .clk    (clk),
      .rst    (rst),
      .acc_q  (acc_q),
      .pm     (pm),
      .addr_q (addr_q),
      .neg_q  (neg_q),
      .vld_q  (vld_q)
   );

   qw_quarter_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .DAC_W(DAC_W)) i_rom (
      .clk    (clk),
      .rst    (rst),
      .addr_q (addr_q),
      .neg_q  (neg_q),
      .vld_q  (vld_q),
      .dac    (dac),
      .inv    (inv)
   );

endmodule

// File: rtl/qw_nco_chk.sv
`timescale 1ns/100ps
module qw_nco_chk #(
   parameter int ACC_W = 32,
   parameter int DAC_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             fw_wr,
   input logic [ACC_W-1:0] fw_data,
   input logic [1:0]       pm,
   input logic [ACC_W-1:0] fw_q,
   input logic [ACC_W-1:0] acc_q,
   input logic [DAC_W-1:0] dac,
   input logic             inv
);

   logic [1:0] since_rst;
   logic [1:0] off;
   logic [1:0] quad_ref;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= 2'd0;
      end else if (since_rst != 2'd3) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   always_comb begin
      unique case (pm)
         2'b00: off = 2'd0;
         2'b01: off = 2'd1;
         2'b11: off = 2'd2;
         2'b10: off = 2'd3;
         default: off = 2'd0;
      endcase
      quad_ref = acc_q[ACC_W-1 -: 2] + off;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dac == '0 && !inv));                              // R1

   AST_FREQ_LOAD: assert property (@(posedge clk) disable iff (rst)
      fw_wr |=> (fw_q == $past(fw_data)));                              // R2

   AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      !fw_wr |=> $stable(fw_q));                                        // R9

   AST_SIGN_TRACKS_PHASE: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2) |-> (dac[DAC_W-1] == $past(quad_ref[1], 2)
                               && inv == $past(quad_ref[1], 2)));       // R3

endmodule

bind qw_nco qw_nco_chk #(.ACC_W(ACC_W), .DAC_W(DAC_W)) i_chk (
   .clk     (clk),
   .rst     (rst),
   .fw_wr   (fw_wr),
   .fw_data (fw_data),
   .pm      (pm),
   .fw_q    (fw_q),
   .acc_q   (acc_q),
   .dac     (dac),
   .inv     (inv)
);

// File: tb/test_qw_nco.sv
`timescale 1ns/100ps
module test_qw_nco;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fw_wr = 1'b0;
   logic [31:0] fw_data = '0;
   logic [1:0]  pm = 2'b00;
   logic [9:0]  dac;
   logic        inv;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   qw_nco i_qw_nco (
      .clk (clk), .rst (rst), .fw_wr (fw_wr), .fw_data (fw_data),
      .pm (pm), .dac (dac), .inv (inv)
   );

   always #2.5 clk = ~clk;

   // timing model of the requirements
   logic [31:0] m_acc, m_fw, m_p1_acc, m_p2_acc;
   logic [1:0]  m_p1_pm, m_p2_pm;
   int          m_cnt;

   always @(posedge clk) begin
      if (rst) begin
         m_acc <= '0; m_fw <= '0; m_cnt <= 0;
         m_p1_acc <= '0; m_p2_acc <= '0; m_p1_pm <= '0; m_p2_pm <= '0;
      end else begin
         if (fw_wr) m_fw <= fw_data;
         m_acc    <= m_acc + m_fw;
         m_p1_acc <= m_acc;
         m_p1_pm  <= pm;
         m_p2_acc <= m_p1_acc;
         m_p2_pm  <= m_p1_pm;
         if (m_cnt < 3) m_cnt <= m_cnt + 1;
      end
   end

   logic [9:0] rec [1024];
   bit         seen [1024];

   function automatic int phase_index(input logic [31:0] a, input logic [1:0] code);
      int offs;
      case (code)
         2'b00: offs = 0;
         2'b01: offs = 256;
         2'b11: offs = 512;
         default: offs = 768;
      endcase
      return (int'(a[31:22]) + offs) % 1024;
   endfunction

   task automatic report(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input string req);
      int    idx;
      real   th, s, em, d;
      bit    es;
      @(negedge clk);
      if (m_cnt < 2) begin
         report(dac == 10'd0 && inv == 1'b0, "R1", {inv, dac}, 0);
      end else begin
         idx = phase_index(m_p2_acc, m_p2_pm);
         th  = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / 1024.0;
         s   = $sin(th);
         es  = (s < 0.0);
         em  = 2047.0 * (es ? -s : s) / 4.0;
         d   = real'(dac[8:0]) - em;
         if (d < 0.0) d = -d;
         rec[idx]  = dac;
         seen[idx] = 1'b1;
         report(dac[9] == es && inv == es && d <= 2.0, req,
                {inv, dac}, {es, es, 9'(int'(em))});
      end
   endtask

   // {step word, shift code, samples}
   localparam logic [49:0] VEC [8] = '{
      {32'h0100_0000, 2'b00, 16'd300},
      {32'h0100_0000, 2'b01, 16'd300},
      {32'h0100_0000, 2'b10, 16'd300},
      {32'h0100_0000, 2'b11, 16'd300},
      {32'h0040_0000, 2'b00, 16'd1100},
      {32'hFFC0_0000, 2'b11, 16'd200},
      {32'h1234_5678, 2'b10, 16'd200},
      {32'h8000_0000, 2'b01, 16'd20}
   };

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [9:0] held;
      for (int i = 0; i < 1024; i++) seen[i] = 1'b0;

      // reset state (R1)
      repeat (3) tick("R1");
      @(negedge clk);
      rst = 1'b0;
      pm  = 2'b10;
      tick("R1");                      // output still quiet
      tick("R1");                      // phase zero with 270 degree offset
      report(dac[9] == 1'b1 && dac[8:0] >= 9'd509, "R1", dac, 10'h3FF);

      // stimulus table: R2 step/wrap, R3 shift codes, R4 magnitude, R5 sign
      for (int v = 0; v < 8; v++) begin
         fw_wr   = 1'b1;
         fw_data = VEC[v][49:18];
         pm      = VEC[v][17:16];
         tick("R2");
         fw_wr   = 1'b0;
         for (int k = 0; k < int'(VEC[v][15:0]); k++) begin
            tick(v < 4 ? "R3" : (v < 5 ? "R4" : "R5"));
         end
      end

      // mirror symmetry over the full phase sweep (R6)
      for (int i = 0; i < 256; i++) begin
         report(seen[i] && seen[511-i] && seen[512+i], "R6", i, 1);
         report(rec[i][8:0] == rec[511-i][8:0], "R6", rec[511-i], rec[i]);
         report(rec[i][8:0] == rec[512+i][8:0] && rec[i][9] == 1'b0
                && rec[512+i][9] == 1'b1, "R6", rec[512+i], {1'b1, rec[i][8:0]});
      end

      // shift code changes while running keep the accumulator on course (R7)
      fw_wr = 1'b1; fw_data = 32'h0210_0000; tick("R7");
      fw_wr = 1'b0;
      for (int k = 0; k < 40; k++) begin
         pm = 2'(k / 3);
         tick("R7");
      end

      // freeze the phase, then measure latency of a shift change (R8)
      fw_wr = 1'b1; fw_data = 32'h0; pm = 2'b00; tick("R8");
      fw_wr = 1'b0;
      repeat (4) tick("R8");
      held = dac;
      pm = 2'b11;                      // half a turn: sign flips
      tick("R8");
      report(dac == held, "R8", dac, held);
      tick("R8");
      report(dac[9] != held[9] && dac[8:0] == held[8:0], "R8",
             dac, {~held[9], held[8:0]});

      // data bus activity without strobe is ignored (R9)
      held = dac;
      for (int k = 0; k < 12; k++) begin
         fw_data = 32'h0400_0000 * (k + 1) + 32'h55;
         tick("R9");
         report(dac == held, "R9", dac, held);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule